// File: doc/BRIEF.md
# Pedestrian-Aware Two-Way Crossing Controller

This block sequences the green/red state of a crossing where a north-south road meets an east-west road. Each direction has one level output: 1 shows green and 0 shows red. With no pedestrian activity, green alternates between the two roads. Every phase has the same length, which is set in clock cycles by a parameter.

A pedestrian walk button may be pressed at any time and for any length. The press is remembered. The phase that is running finishes unchanged. At the next boundary the controller enters a walk phase of the same length, with both outputs high. Alternation then resumes, and green goes to the road that did not have it just before the walk phase.

Top module: `ped_crossing_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the outputs are ns_green=0 and ew_green=1 with no walk request pending. A walk_req held high during reset is forgotten.
- R2: Every phase lasts exactly PHASE_CYCLES clock cycles. The outputs change only at a phase boundary, and they change at every boundary.
- R3: With no walk_req, phases alternate as {ns_green,ew_green}=01 followed by 10, indefinitely.
- R4: A walk_req pulse in a traffic phase does not alter that phase. The next phase is a walk phase with {ns_green,ew_green}=11.
- R5: A walk_req that is high only in the last cycle of a traffic phase is served at that same boundary.
- R6: After a walk phase, green goes to the road that did not have green in the traffic phase just before the walk phase.
- R7: A walk_req during a walk phase is kept. It is not served at the end of that walk phase: one traffic phase follows, and the walk phase comes after it. Two walk phases never run back to back.
- R8: Any number of presses within one traffic phase produce a single walk phase.
- R9: The outputs never show red on both roads ({ns_green,ew_green}=00 never appears).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_req | input | 1 | Pedestrian button, level or pulse |
| ns_green | output | 1 | North-south road: 1 green, 0 red |
| ew_green | output | 1 | East-west road: 1 green, 0 red |

## Verification
A button press can land on the same cycle as the terminal count of the phase timer. It can also reach into the cycle in which a walk phase begins, where the request flag is being cleared. The bench provokes the first case with a press only on the last cycle of a traffic phase, and expects the very next phase to be the walk phase. It provokes the second case by holding the button through a traffic phase and the walk phase that follows it. The press seen during that walk phase must survive the clear: one traffic phase runs, then a second walk phase comes.

// File: rtl/xing_pkg.sv
package xing_pkg;

    // Bit 1 drives the north-south lamp and bit 0 the east-west lamp.
    typedef enum logic [1:0] {
        PH_EW   = 2'b01,
        PH_NS   = 2'b10,
        PH_WALK = 2'b11
    } phase_e;

    typedef struct packed {
        logic ns;
        logic ew;
    } lamp_t;

    function automatic phase_e other_road(input phase_e p);
        return (p == PH_EW) ? PH_NS : PH_EW;
    endfunction

    function automatic lamp_t lamps_of(input phase_e p);
        lamp_t l;
        l.ns = p[1];
        l.ew = p[0];
        return l;
    endfunction

endpackage

// File: rtl/xing_phase_timer.sv
module xing_phase_timer #(
    parameter int PHASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic last_cycle
);
    localparam int CNT_W = $clog2(PHASE_CYCLES > 1 ? PHASE_CYCLES : 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_cycle = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || last_cycle) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/xing_walk_latch.sv
module xing_walk_latch (
    input  logic clk,
    input  logic rst,
    input  logic walk_req,
    input  logic last_cycle,
    input  logic in_walk,
    output logic serve_walk
);
    logic held_q;

    // A request counts if it was held earlier or is present in this cycle.
    assign serve_walk = held_q | walk_req;

    always_ff @(posedge clk) begin
        if (rst)                        held_q <= 1'b0;
        else if (last_cycle && !in_walk) held_q <= 1'b0;
        else                            held_q <= held_q | walk_req;
    end
endmodule

// File: rtl/xing_sequencer.sv
module xing_sequencer
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   last_cycle,
    input  logic   serve_walk,
    output phase_e phase,
    output logic   in_walk
);
    phase_e phase_q, resume_q;
    phase_e phase_d, resume_d;

    assign phase   = phase_q;
    assign in_walk = (phase_q == PH_WALK);

    always_comb begin
        phase_d  = phase_q;
        resume_d = resume_q;
        if (last_cycle) begin
            if (in_walk) begin
                phase_d = resume_q;
            end else begin
                resume_d = other_road(phase_q);
                phase_d  = serve_walk ? PH_WALK : other_road(phase_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_EW;
            resume_q <= PH_NS;
        end else begin
            phase_q  <= phase_d;
            resume_q <= resume_d;
        end
    end
endmodule

// File: rtl/ped_crossing_ctrl.sv
module ped_crossing_ctrl
    import xing_pkg::*;
#(
    parameter int PHASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic walk_req,
    output logic ns_green,
    output logic ew_green
);
    logic   last_cycle;
    logic   serve_walk;
    logic   in_walk;
    phase_e phase;
    lamp_t  lamps;

    xing_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .last_cycle (last_cycle)
    );

    xing_walk_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .walk_req   (walk_req),
        .last_cycle (last_cycle),
        .in_walk    (in_walk),
        .serve_walk (serve_walk)
    );

    xing_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .last_cycle (last_cycle),
        .serve_walk (serve_walk),
        .phase      (phase),
        .in_walk    (in_walk)
    );

    assign lamps    = lamps_of(phase);
    assign ns_green = lamps.ns;
    assign ew_green = lamps.ew;
endmodule

// File: rtl/ped_crossing_ctrl_chk.sv
module ped_crossing_ctrl_chk #(
    parameter int PHASE_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic walk_req,
    input logic ns_green,
    input logic ew_green
);
    logic       ns_p, ew_p;
    logic [1:0] pre_walk_q;
    logic       seen_q;
    int         age_q;

    logic both_now, both_prev, chg, enter_walk;
    assign both_now   = ns_green & ew_green;
    assign both_prev  = ns_p & ew_p;
    assign chg        = (ns_green != ns_p) || (ew_green != ew_p);
    assign enter_walk = both_now && !both_prev;

    always_ff @(posedge clk) begin
        ns_p <= ns_green;
        ew_p <= ew_green;
        if (rst) begin
            age_q      <= 0;
            seen_q     <= 1'b0;
            pre_walk_q <= 2'b01;
        end else begin
            age_q      <= chg ? 1 : age_q + 1;
            seen_q     <= enter_walk ? walk_req : (seen_q | walk_req);
            if (!both_now) pre_walk_q <= {ns_green, ew_green};
        end
    end

    a_r1_reset_phase: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ns_green && ew_green));

    a_r2_change_on_boundary: assert property (@(posedge clk) disable iff (rst)
        chg |-> (age_q == PHASE_CYCLES));

    a_r2_no_overstay: assert property (@(posedge clk) disable iff (rst)
        (age_q == PHASE_CYCLES) |-> chg);

    a_r6_resume_other: assert property (@(posedge clk) disable iff (rst)
        (both_prev && !both_now) |-> ({ns_green, ew_green} != pre_walk_q));

    a_r4_walk_needs_request: assert property (@(posedge clk) disable iff (rst)
        enter_walk |-> seen_q);
endmodule

bind ped_crossing_ctrl ped_crossing_ctrl_chk #(.PHASE_CYCLES(PHASE_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .walk_req (walk_req),
    .ns_green (ns_green),
    .ew_green (ew_green)
);

// File: tb/tb_ped_crossing_ctrl.sv
`timescale 1ns/1ps
module tb_ped_crossing_ctrl;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic walk_req = 1'b0;
    logic ns_green, ew_green;

    always #2 clk = ~clk;

    ped_crossing_ctrl #(.PHASE_CYCLES(P)) dut (
        .clk      (clk),
        .rst      (rst),
        .walk_req (walk_req),
        .ns_green (ns_green),
        .ew_green (ew_green)
    );

    typedef struct {
        logic  ns;
        logic  ew;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   running = 0;
    bit   done = 0;

    // Bench model: 0 = east-west green, 1 = north-south green, 2 = walk
    int m_cur = 0;
    int m_last_tr = 0;
    bit m_pend = 0;

    task automatic check2(input logic ns_a, input logic ew_a,
                          input logic ns_e, input logic ew_e, input string tag);
        checks++;
        if (ns_a !== ns_e || ew_a !== ew_e) begin
            errors++;
            $display("FAIL %s: got ns=%b ew=%b, expected ns=%b ew=%b at %0t",
                     tag, ns_a, ew_a, ns_e, ew_e, $time);
        end
    endtask

    // Driver: pushes the phase it expects, then presses per mask bit.
    task automatic run_phase(input logic [31:0] mask, input string tag);
        exp_t e;
        bit   pressed;
        e.ns  = (m_cur != 0);
        e.ew  = (m_cur != 1);
        e.tag = tag;
        exp_q.push_back(e);
        pressed = 0;
        for (int i = 0; i < P; i++) begin
            walk_req = mask[i];
            if (mask[i]) pressed = 1;
            @(negedge clk);
        end
        walk_req = 1'b0;
        if (m_cur == 2) begin
            m_cur  = 1 - m_last_tr;
            m_pend = m_pend | pressed;
        end else if (m_pend || pressed) begin
            m_last_tr = m_cur;
            m_cur     = 2;
            m_pend    = 0;
        end else begin
            m_cur = 1 - m_cur;
        end
    endtask

    // Monitor: pops one expected phase per P cycles, compares every cycle.
    exp_t cur_e;
    int   mon_n = 0;
    always @(negedge clk) begin
        #1;
        if (running) begin
            if (mon_n % P == 0) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: scoreboard empty, got ns=%b ew=%b, expected a queued phase",
                             ns_green, ew_green);
                end else begin
                    cur_e = exp_q.pop_front();
                end
            end
            check2(ns_green, ew_green, cur_e.ns, cur_e.ew, cur_e.tag);
            checks++;
            if (!ns_green && !ew_green) begin
                errors++;
                $display("FAIL R9: got ns=0 ew=0, expected at least one green");
            end
            mon_n++;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: button held through reset must be forgotten
        walk_req = 1'b1;
        repeat (4) @(negedge clk);
        check2(ns_green, ew_green, 1'b0, 1'b1, "R1 during reset");
        walk_req = 1'b0;
        rst = 1'b0;
        running = 1;
        run_phase(32'h0, "R1 first phase");
        run_phase(32'h0, "R1 R3 no stale walk");
        run_phase(32'h8, "R4 phase unchanged by press");
        run_phase(32'h0, "R4 walk phase");
        run_phase(32'h22, "R6 resume after EW");
        run_phase(32'h0, "R8 single walk");
        run_phase(32'h0, "R6 resume after NS");
        run_phase(32'(1) << (P - 1), "R5 last-cycle press phase");
        run_phase(32'hFF, "R5 walk at same boundary");
        run_phase(32'h0, "R7 traffic after walk");
        run_phase(32'h0, "R7 held walk");
        run_phase(32'hFF, "R7 long press traffic");
        run_phase(32'hFF, "R7 long press walk");
        run_phase(32'h0, "R7 no back-to-back walk");
        run_phase(32'h0, "R7 held walk served");
        run_phase(32'h0, "R3 alternation resumes");
        run_phase(32'h0, "R3 alternation");
        run_phase(32'h0, "R2 R3 alternation");
        running = 0;
        done = 1;
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2: got %0d phases unchecked, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule